// File: doc/BRIEF.md
# Binary XNOR-Popcount Tile Engine

This block computes one output tile of a binarized neural-network layer. It captures a TP-bit input feature vector and holds it. It then takes TP weight vectors, one per cycle. For each weight vector it forms the bitwise XNOR with the held feature vector and clears the lanes at or above the configured active input count. It counts the remaining ones in a reduction tree and adds the count into the saturating accumulator that belongs to that weight vector. Once every accumulator is final, the block takes one vector of TP threshold bytes, compares each accumulator with its decoded and shifted threshold, and emits a TP-bit binary result.

All data moves over valid/ready streams. Weights enter through a four-entry FIFO. The feature, threshold and result streams each pass through a two-entry FIFO. A keep control lets several feature vectors, each with its own TP weights, add into the same accumulators before one thresholding step. Address generation and loop sequencing belong to the surrounding logic.

Top module: `xnor_tile_engine`

## Requirements
- R1: After reset, out_valid_o is 0 and feat_ready_o, wgt_ready_o and thr_ready_o are 1.
- R2: In a pass, the j-th accepted weight vector (j = 0..TP-1) adds to accumulator j the number of lanes i below cfg_active_i where weight bit i equals feature bit i. Bit i of the result belongs to accumulator i.
- R3: Lanes with index at or above cfg_active_i add nothing, and a value of 0 adds zero for every weight vector.
- R4: Threshold byte g sits at thr_data_i[8g+7:8g]. Bits 5:0 hold the magnitude, bit 6 makes the value negative when set, and bit 7 selects the comparison direction.
- R5: When bit 7 is 0, the result bit is 1 if the accumulator is greater than or equal to the threshold. When bit 7 is 1, the result bit is 1 if the accumulator is strictly less than the threshold.
- R6: The signed threshold value is multiplied by 2 to the power cfg_shift_i (range 0..15) before the comparison.
- R7: cfg_keep_i is sampled with the last weight of a pass. If it is 1, no threshold is consumed and no result is produced, and the next pass adds into the same accumulators. If it is 0, the next threshold vector is consumed and a result is produced.
- R8: Every accumulator is zero at the start of the pass that follows a produced result.
- R9: Accumulators are 16 bits wide and saturate at 65535 instead of wrapping.
- R10: While out_ready_i is 0, up to two results are kept in order, with out_valid_o held high and out_data_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_active_i | input | $clog2(TP+1) | Number of active input lanes |
| cfg_shift_i | input | 4 | Left shift applied to thresholds |
| cfg_keep_i | input | 1 | Keep accumulating after this pass |
| feat_valid_i | input | 1 | Feature vector valid |
| feat_ready_o | output | 1 | Feature FIFO can accept |
| feat_data_i | input | TP | Input feature vector |
| wgt_valid_i | input | 1 | Weight vector valid |
| wgt_ready_o | output | 1 | Weight FIFO can accept |
| wgt_data_i | input | TP | Weight vector |
| thr_valid_i | input | 1 | Threshold vector valid |
| thr_ready_o | output | 1 | Threshold FIFO can accept |
| thr_data_i | input | 8*TP | Packed threshold bytes, byte g for lane g |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result accepted |
| out_data_o | output | TP | Binary result vector |

## Verification
The hardest state to reach is accumulator saturation. A full-match weight adds at most TP per beat, so the bench chains 2050 keep-mode passes of all-ones feature and weight vectors. That drives every accumulator to 65535, and a threshold shifted by ten separates the saturated value from a wrapped one. A second hard case is a threshold vector that arrives while a keep-mode tile is still in progress. The bench queues that threshold early and checks that no result appears until the final pass completes.

// File: rtl/xte_pkg.sv
package xte_pkg;
  localparam int THR_W = 24;
  localparam int SH_W  = 4;

  typedef enum logic [1:0] {ST_FEAT, ST_ACC, ST_THR} xte_state_e;

  // byte: [7] direction, [6] negative, [5:0] magnitude
  function automatic logic signed [THR_W-1:0] thr_decode(input logic [7:0] b,
                                                         input logic [SH_W-1:0] sh);
    logic signed [THR_W-1:0] v;
    v = signed'({{(THR_W-6){1'b0}}, b[5:0]});
    if (b[6]) v = -v;
    return v <<< sh;
  endfunction
endpackage

// File: rtl/xte_fifo.sv
module xte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push, pop;

  assign in_ready_o  = (cnt_q != CW'(DEPTH));
  assign out_valid_o = (cnt_q != '0);
  assign out_data_o  = mem_q[rp_q];
  assign push        = in_valid_i && in_ready_o;
  assign pop         = out_valid_o && out_ready_i;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push) begin
        mem_q[wp_q] <= in_data_i;
        wp_q        <= ptr_next(wp_q);
      end
      if (pop) rp_q <= ptr_next(rp_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/xte_popcount.sv
module xte_popcount #(
  parameter int TP    = 32,
  parameter int CNT_W = $clog2(TP + 1)
) (
  input  logic [TP-1:0]    bits_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int LVL = (TP > 1) ? $clog2(TP) : 0;
  localparam int P   = 1 << LVL;

  // heap-ordered adder tree: node n sums nodes 2n+1 and 2n+2
  logic [CNT_W-1:0] node [2*P-1];

  always_comb begin
    for (int g = 0; g < P; g++)
      node[P-1+g] = (g < TP) ? CNT_W'(bits_i[g]) : '0;
    for (int n = P - 2; n >= 0; n--)
      node[n] = node[2*n+1] + node[2*n+2];
  end

  assign cnt_o = node[0];
endmodule

// File: rtl/xte_acc_bank.sv
module xte_acc_bank #(
  parameter int TP    = 32,
  parameter int ACC_W = 16,
  parameter int CNT_W = $clog2(TP + 1),
  parameter int IDX_W = (TP > 1) ? $clog2(TP) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                add_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic [TP*ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q [TP];

  for (genvar g = 0; g < TP; g++) begin : g_lane
    logic [ACC_W:0] sum;
    assign sum = {1'b0, acc_q[g]} + (ACC_W+1)'(cnt_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          acc_q[g] <= '0;
      else if (clr_i)                       acc_q[g] <= '0;
      else if (add_i && idx_i == IDX_W'(g)) acc_q[g] <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
    end

    assign acc_o[g*ACC_W +: ACC_W] = acc_q[g];
  end
endmodule

// File: rtl/xte_thresh.sv
module xte_thresh
  import xte_pkg::*;
#(
  parameter int TP    = 32,
  parameter int ACC_W = 16
) (
  input  logic [TP*ACC_W-1:0] acc_i,
  input  logic [8*TP-1:0]     thr_i,
  input  logic [SH_W-1:0]     shift_i,
  output logic [TP-1:0]       bits_o
);
  for (genvar g = 0; g < TP; g++) begin : g_cmp
    logic [7:0]              tb;
    logic signed [THR_W-1:0] tv, av;
    logic                    ge;
    assign tb        = thr_i[8*g +: 8];
    assign tv        = thr_decode(tb, shift_i);
    assign av        = signed'(THR_W'(acc_i[g*ACC_W +: ACC_W]));
    assign ge        = (av >= tv);
    assign bits_o[g] = tb[7] ? !ge : ge;
  end
endmodule

// File: rtl/xnor_tile_engine.sv
module xnor_tile_engine
  import xte_pkg::*;
#(
  parameter int TP          = 32,
  parameter int ACC_W       = 16,
  parameter int WGT_DEPTH   = 4,
  parameter int DEC_DEPTH   = 2,
  localparam int AC_W       = $clog2(TP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AC_W-1:0]   cfg_active_i,
  input  logic [SH_W-1:0]   cfg_shift_i,
  input  logic              cfg_keep_i,
  input  logic              feat_valid_i,
  output logic              feat_ready_o,
  input  logic [TP-1:0]     feat_data_i,
  input  logic              wgt_valid_i,
  output logic              wgt_ready_o,
  input  logic [TP-1:0]     wgt_data_i,
  input  logic              thr_valid_i,
  output logic              thr_ready_o,
  input  logic [8*TP-1:0]   thr_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [TP-1:0]     out_data_o
);
  localparam int IDX_W = (TP > 1) ? $clog2(TP) : 1;
  localparam int CNT_W = AC_W;

  xte_state_e         state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [TP-1:0]      feat_q;

  logic               f_vld, f_rdy;
  logic [TP-1:0]      f_data;
  logic               w_vld, w_rdy;
  logic [TP-1:0]      w_data;
  logic               t_vld, t_rdy;
  logic [8*TP-1:0]    t_data;
  logic               o_vld, o_rdy;
  logic [TP-1:0]      o_data;

  logic [TP-1:0]      lane_mask, masked;
  logic [CNT_W-1:0]   pop_cnt;
  logic [TP*ACC_W-1:0] acc_flat;
  logic               w_pop, acc_clr, last_w;

  xte_fifo #(.W(TP), .DEPTH(DEC_DEPTH)) u_feat_fifo (
    .clk_i, .rst_ni,
    .in_valid_i(feat_valid_i), .in_ready_o(feat_ready_o), .in_data_i(feat_data_i),
    .out_valid_o(f_vld), .out_ready_i(f_rdy), .out_data_o(f_data)
  );

  xte_fifo #(.W(TP), .DEPTH(WGT_DEPTH)) u_wgt_fifo (
    .clk_i, .rst_ni,
    .in_valid_i(wgt_valid_i), .in_ready_o(wgt_ready_o), .in_data_i(wgt_data_i),
    .out_valid_o(w_vld), .out_ready_i(w_rdy), .out_data_o(w_data)
  );

  xte_fifo #(.W(8*TP), .DEPTH(DEC_DEPTH)) u_thr_fifo (
    .clk_i, .rst_ni,
    .in_valid_i(thr_valid_i), .in_ready_o(thr_ready_o), .in_data_i(thr_data_i),
    .out_valid_o(t_vld), .out_ready_i(t_rdy), .out_data_o(t_data)
  );

  xte_fifo #(.W(TP), .DEPTH(DEC_DEPTH)) u_out_fifo (
    .clk_i, .rst_ni,
    .in_valid_i(o_vld), .in_ready_o(o_rdy), .in_data_i(o_data),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o)
  );

  always_comb begin
    for (int i = 0; i < TP; i++)
      lane_mask[i] = (i < int'(cfg_active_i));
  end

  assign masked  = ~(w_data ^ feat_q) & lane_mask;
  assign f_rdy   = (state_q == ST_FEAT);
  assign w_rdy   = (state_q == ST_ACC);
  assign w_pop   = w_rdy && w_vld;
  assign last_w  = (idx_q == IDX_W'(TP - 1));
  assign o_vld   = (state_q == ST_THR) && t_vld;
  assign t_rdy   = (state_q == ST_THR) && o_rdy;
  assign acc_clr = t_vld && t_rdy;

  xte_popcount #(.TP(TP), .CNT_W(CNT_W)) u_popcount (
    .bits_i(masked), .cnt_o(pop_cnt)
  );

  xte_acc_bank #(.TP(TP), .ACC_W(ACC_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_acc_bank (
    .clk_i, .rst_ni,
    .clr_i(acc_clr), .add_i(w_pop), .idx_i(idx_q), .cnt_i(pop_cnt), .acc_o(acc_flat)
  );

  xte_thresh #(.TP(TP), .ACC_W(ACC_W)) u_thresh (
    .acc_i(acc_flat), .thr_i(t_data), .shift_i(cfg_shift_i), .bits_o(o_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FEAT;
      idx_q   <= '0;
      feat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_FEAT: if (f_vld) begin
          feat_q  <= f_data;
          idx_q   <= '0;
          state_q <= ST_ACC;
        end
        ST_ACC: if (w_vld) begin
          idx_q <= idx_q + 1'b1;
          if (last_w) state_q <= cfg_keep_i ? ST_FEAT : ST_THR;
        end
        ST_THR: if (acc_clr) state_q <= ST_FEAT;
        default: state_q <= ST_FEAT;
      endcase
    end
  end
endmodule

// File: rtl/xte_checker.sv
module xte_checker #(
  parameter int TP    = 32,
  parameter int ACC_W = 16,
  parameter int CNT_W = $clog2(TP + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic [TP-1:0]       out_data_o,
  input logic [TP*ACC_W-1:0] acc_flat,
  input logic                acc_clr,
  input logic                w_pop,
  input logic [TP-1:0]       masked,
  input logic [CNT_W-1:0]    pop_cnt,
  input logic [CNT_W-1:0]    cfg_active_i
);
  // R10
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R3
  mask_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_pop && cfg_active_i == '0 |-> pop_cnt == '0);

  // R2
  popcnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_pop |-> int'(pop_cnt) == $countones(masked));

  // R8
  acc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_clr |=> acc_flat == '0);

  // R9
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_clr |=> acc_flat[ACC_W-1:0] >= $past(acc_flat[ACC_W-1:0]));
endmodule

bind xnor_tile_engine xte_checker #(.TP(TP), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_xte_checker (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
  .acc_flat(acc_flat), .acc_clr(acc_clr), .w_pop(w_pop), .masked(masked),
  .pop_cnt(pop_cnt), .cfg_active_i(cfg_active_i)
);

// File: tb/tb_xnor_tile_engine.sv
module tb_xnor_tile_engine;
  localparam int TP         = 32;
  localparam int ACC_W      = 16;
  localparam int AC_W       = $clog2(TP + 1);
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 195000;
  localparam int ACC_MAX    = (1 << ACC_W) - 1;
  localparam int VEC_N      = 6;

  typedef struct packed {
    logic [31:0] seed;
    logic [7:0]  act;
    logic [3:0]  sh;
  } vec_t;

  localparam vec_t VECS [VEC_N] = '{
    '{32'h0000_0001, 8'd32, 4'd0},
    '{32'h0000_002a, 8'd32, 4'd1},
    '{32'h0000_0077, 8'd17, 4'd0},
    '{32'h0000_1234, 8'd1,  4'd0},
    '{32'h0000_beef, 8'd31, 4'd2},
    '{32'h0000_0005, 8'd24, 4'd1}
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [AC_W-1:0] cfg_active_i = '0;
  logic [3:0]      cfg_shift_i = '0;
  logic            cfg_keep_i = 1'b0;
  logic            feat_valid_i = 1'b0, wgt_valid_i = 1'b0, thr_valid_i = 1'b0;
  logic            out_ready_i = 1'b0;
  logic [TP-1:0]   feat_data_i = '0, wgt_data_i = '0;
  logic [8*TP-1:0] thr_data_i = '0;
  logic            feat_ready_o, wgt_ready_o, thr_ready_o, out_valid_o;
  logic [TP-1:0]   out_data_o;

  xnor_tile_engine #(.TP(TP), .ACC_W(ACC_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_active_i(cfg_active_i), .cfg_shift_i(cfg_shift_i), .cfg_keep_i(cfg_keep_i),
    .feat_valid_i(feat_valid_i), .feat_ready_o(feat_ready_o), .feat_data_i(feat_data_i),
    .wgt_valid_i(wgt_valid_i), .wgt_ready_o(wgt_ready_o), .wgt_data_i(wgt_data_i),
    .thr_valid_i(thr_valid_i), .thr_ready_o(thr_ready_o), .thr_data_i(thr_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int              checks = 0, errors = 0;
  bit              done = 1'b0;
  int              macc [TP];
  logic [31:0]     seed;
  logic [TP-1:0]   fbuf;
  logic [TP-1:0]   wbuf [TP];
  logic [8*TP-1:0] tbuf;

  function automatic logic [31:0] lcg(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic rand_vec(output logic [TP-1:0] v);
    for (int b = 0; b < TP; b++) begin
      seed = lcg(seed);
      v[b] = seed[16];
    end
  endtask

  task automatic check_vec(input string req, input logic [TP-1:0] got, input logic [TP-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_int(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic push_feat(input logic [TP-1:0] d);
    logic hs;
    feat_data_i = d; feat_valid_i = 1'b1;
    do begin hs = feat_ready_o; @(negedge clk); end while (!hs);
    feat_valid_i = 1'b0;
  endtask

  task automatic push_wgt(input logic [TP-1:0] d);
    logic hs;
    wgt_data_i = d; wgt_valid_i = 1'b1;
    do begin hs = wgt_ready_o; @(negedge clk); end while (!hs);
    wgt_valid_i = 1'b0;
  endtask

  task automatic push_thr(input logic [8*TP-1:0] d);
    logic hs;
    thr_data_i = d; thr_valid_i = 1'b1;
    do begin hs = thr_ready_o; @(negedge clk); end while (!hs);
    thr_valid_i = 1'b0;
  endtask

  task automatic pop_out(output logic [TP-1:0] d);
    logic hs;
    out_ready_i = 1'b1;
    do begin hs = out_valid_o; d = out_data_o; @(negedge clk); end while (!hs);
    out_ready_i = 1'b0;
  endtask

  // reference: bitwise match count per weight vector, saturating sum
  task automatic model_pass(input int act);
    for (int j = 0; j < TP; j++) begin
      int c = 0;
      for (int i = 0; i < TP; i++)
        if (i < act && wbuf[j][i] == fbuf[i]) c++;
      macc[j] = (macc[j] + c > ACC_MAX) ? ACC_MAX : macc[j] + c;
    end
  endtask

  task automatic model_out(input int sh, output logic [TP-1:0] e);
    for (int g = 0; g < TP; g++) begin
      logic [7:0] b = tbuf[8*g +: 8];
      int v = int'(b[5:0]);
      bit ge;
      if (b[6]) v = -v;
      v = v * (1 << sh);
      ge = (macc[g] >= v);
      e[g] = b[7] ? !ge : ge;
      macc[g] = 0;
    end
  endtask

  task automatic run_pass(input int act, input bit keep);
    cfg_active_i = AC_W'(act);
    cfg_keep_i = keep;
    push_feat(fbuf);
    for (int j = 0; j < TP; j++) push_wgt(wbuf[j]);
    repeat (6) @(negedge clk);
    model_pass(act);
  endtask

  task automatic finish_tile(input string req, input int sh);
    logic [TP-1:0] got, exp;
    cfg_shift_i = 4'(sh);
    push_thr(tbuf);
    model_out(sh, exp);
    pop_out(got);
    check_vec(req, got, exp);
  endtask

  function automatic logic [7:0] tbyte(input bit dir, input bit neg, input int mag);
    return {dir, neg, 6'(mag)};
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all R): got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TP-1:0] ga, gb, ea, eb, hold;
    for (int g = 0; g < TP; g++) macc[g] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_int("R1 out_valid", int'(out_valid_o), 0);
    check_int("R1 feat_ready", int'(feat_ready_o), 1);
    check_int("R1 wgt_ready", int'(wgt_ready_o), 1);
    check_int("R1 thr_ready", int'(thr_ready_o), 1);

    // R2 R4: table of random tiles
    for (int k = 0; k < VEC_N; k++) begin
      seed = VECS[k].seed;
      rand_vec(fbuf);
      for (int j = 0; j < TP; j++) rand_vec(wbuf[j]);
      for (int g = 0; g < TP; g++) begin
        int m;
        seed = lcg(seed);
        m = int'(seed[23:8] % 16'(VECS[k].act + 1)) >> VECS[k].sh;
        tbuf[8*g +: 8] = tbyte(seed[27], seed[29] & seed[30], m);
      end
      run_pass(int'(VECS[k].act), 1'b0);
      finish_tile("R2 R4 table", int'(VECS[k].sh));
    end

    // R3 partial lanes: count 5 everywhere
    fbuf = '1;
    for (int j = 0; j < TP; j++) wbuf[j] = '1;
    for (int g = 0; g < TP; g++) tbuf[8*g +: 8] = tbyte(1'b0, 1'b0, 4 + g % 3);
    run_pass(5, 1'b0);
    finish_tile("R3 active=5", 0);
    // R3 no lanes active
    for (int g = 0; g < TP; g++) tbuf[8*g +: 8] = tbyte(1'b0, 1'b0, 1);
    run_pass(0, 1'b0);
    finish_tile("R3 active=0", 0);

    // R5 direction and negative thresholds, count TP
    seed = 32'h0bad_cafe;
    rand_vec(fbuf);
    for (int j = 0; j < TP; j++) wbuf[j] = fbuf;
    for (int g = 0; g < TP; g++)
      case (g % 4)
        0: tbuf[8*g +: 8] = tbyte(1'b0, 1'b0, TP);
        1: tbuf[8*g +: 8] = tbyte(1'b1, 1'b0, TP);
        2: tbuf[8*g +: 8] = tbyte(1'b1, 1'b1, 5);
        default: tbuf[8*g +: 8] = tbyte(1'b0, 1'b1, 5);
      endcase
    run_pass(TP, 1'b0);
    finish_tile("R5 direction", 0);

    // R6 shift: 8<<2 passes, 9<<2 fails; unshifted both pass
    for (int g = 0; g < TP; g++) tbuf[8*g +: 8] = tbyte(1'b0, 1'b0, 8 + g % 2);
    run_pass(TP, 1'b0);
    finish_tile("R6 shift=2", 2);
    run_pass(TP, 1'b0);
    finish_tile("R6 shift=0", 0);

    // R7 keep: threshold queued early must wait for the final pass
    for (int g = 0; g < TP; g++) tbuf[8*g +: 8] = tbyte(1'b0, 1'b0, TP + g % 2);
    cfg_shift_i = 4'd1;
    run_pass(TP, 1'b1);
    push_thr(tbuf);
    repeat (8) @(negedge clk);
    check_int("R7 no result after keep pass", int'(out_valid_o), 0);
    run_pass(TP, 1'b0);
    model_out(1, ea);
    pop_out(ga);
    check_vec("R7 two-pass sum", ga, ea);

    // R8 accumulators restart at zero
    for (int g = 0; g < TP; g++) tbuf[8*g +: 8] = tbyte(1'b0, 1'b0, 1);
    run_pass(0, 1'b0);
    finish_tile("R8 cleared", 0);

    // R10 two results held under backpressure
    seed = 32'h1357_9bdf;
    rand_vec(fbuf);
    for (int j = 0; j < TP; j++) rand_vec(wbuf[j]);
    for (int g = 0; g < TP; g++) tbuf[8*g +: 8] = tbyte(g[0], 1'b0, 16);
    cfg_shift_i = 4'd0;
    run_pass(TP, 1'b0);
    push_thr(tbuf);
    model_out(0, ea);
    rand_vec(fbuf);
    for (int j = 0; j < TP; j++) rand_vec(wbuf[j]);
    for (int g = 0; g < TP; g++) tbuf[8*g +: 8] = tbyte(1'b0, 1'b0, 14 + g % 5);
    run_pass(TP, 1'b0);
    push_thr(tbuf);
    model_out(0, eb);
    repeat (5) @(negedge clk);
    check_int("R10 valid held", int'(out_valid_o), 1);
    hold = out_data_o;
    repeat (3) @(negedge clk);
    check_vec("R10 data stable", out_data_o, hold);
    pop_out(ga);
    pop_out(gb);
    check_vec("R10 first result", ga, ea);
    check_vec("R10 second result", gb, eb);

    // R9 saturation: 2050 full-match passes reach 65600 without limit
    fbuf = '1;
    for (int j = 0; j < TP; j++) wbuf[j] = '1;
    for (int p = 0; p < 2050; p++) run_pass(TP, p != 2049);
    check_int("R9 model saturated", macc[0], ACC_MAX);
    for (int g = 0; g < TP; g++) tbuf[8*g +: 8] = tbyte(g[0], 1'b0, 63);
    finish_tile("R9 saturate", 10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule